// File: doc/BRIEF.md
# Flash Write Guard and Block Splitter

This block sits between a host that asks for flash writes and the sequencer that runs the flash command timing. It keeps two write-permission flags, set and cleared by short control commands. The first is a general enable. The second unlocks the lowest 64 KB block, which holds boot code. When a write request arrives, the block checks the request against these flags and against the size of the device that is fitted. If the request is accepted, the block cuts it into one job per 64 KB block.

For each block the guard first asks the sequencer for an erase and then for a program of that block's byte span. The span is clipped so that it never crosses the block end. The sequencer answers every job with a one-cycle done or error pulse. A failed erase is retried, and a failed program verification sends the block back to erase. Each kind of attempt has its own limit. At the end the guard sends one result pulse. The pulse carries a status and the number of bytes that completed, and that count is correct even when the write aborts partway through.

The control FSM has four states:
- IDLE waits for a request.
- ERASE_BLK presents an erase job.
- PROG_BLK presents a program job.
- REPORT drives the result for one cycle.

The transitions are:
- IDLE→REPORT when a request is rejected or covers zero blocks.
- IDLE→ERASE_BLK when a request is accepted.
- ERASE_BLK→ERASE_BLK on an erase error with attempts left.
- ERASE_BLK→PROG_BLK on erase done.
- ERASE_BLK→REPORT on erase error at the limit.
- PROG_BLK→ERASE_BLK on program done with blocks left, or on a program error with attempts left.
- PROG_BLK→REPORT on program done of the last block, or on a program error at the limit.
- REPORT→IDLE always.

Top module: `flash_wr_guard`

## Requirements
- R1: Commands are taken when `cmd_valid` is high, and each one takes effect at that clock edge. Code 2'b00 clears both enables. 2'b01 sets the general enable. 2'b10 sets the low-block enable. 2'b11 clears both enables and raises `cmd_bad` for exactly the following cycle.
- R2: A request made while the general enable is clear is rejected. Rejection means no job is issued, and one cycle after the request `res_valid` pulses with `res_status`=1 and `res_bytes`=0.
- R3: A request whose start is below 0x10000 is rejected unless the low-block enable is also set.
- R4: A request is rejected when start+count exceeds the device size: 1 MB when `size_sel`=0, 4 MB when `size_sel`=1. A request for which start+count equals the size exactly is accepted.
- R5: The number of blocks is ((start+count)>>16) − (start>>16) + 1, less one when start+count is a multiple of 0x10000. The first block is start>>16, and the following blocks are consecutive. A request that covers zero blocks reports status 0 with 0 bytes.
- R6: Each job carries `job_blk`, the offset inside the block `job_off`, and the length `job_len`. The first block starts at start[15:0] and later blocks start at offset 0. The length is the smaller of the bytes still remaining and 0x10000 minus the offset.
- R7: For every block an erase job (`job_kind`=0) comes first, then a program job (`job_kind`=1) with the same block, offset and length.
- R8: Erase attempts on a block are counted up to 10, and the count carries over when a block is re-erased. An erase error on the 10th attempt ends the write with status 2.
- R9: A program error sends the block back to erase and then to program again. An error on the 10th program attempt of a block ends the write with status 2.
- R10: `res_bytes` is the sum of the lengths of the completed program jobs. This holds for a full success (status 0) and also for an abort.
- R11: A `wr_req` that arrives while `busy` is high is ignored and does not change the jobs or the result.
- R12: `busy` is low only in IDLE. `job_valid` is high only in ERASE_BLK and PROG_BLK. `res_valid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Control command strobe |
| cmd | input | 2 | Control command code |
| cmd_bad | output | 1 | Unrecognised command seen in the previous cycle |
| size_sel | input | 1 | Device size select: 0 = 1 MB, 1 = 4 MB |
| wr_req | input | 1 | Write request strobe |
| wr_start | input | 22 | Start byte offset |
| wr_count | input | 23 | Byte count |
| busy | output | 1 | A request is being processed |
| job_valid | output | 1 | A job is presented to the sequencer |
| job_kind | output | 1 | 0 = erase, 1 = program |
| job_blk | output | 6 | Block index |
| job_off | output | 16 | Start offset inside the block |
| job_len | output | 17 | Bytes to program in this block |
| job_done | input | 1 | Job completed without error |
| job_err | input | 1 | Job failed |
| res_valid | output | 1 | Result pulse |
| res_status | output | 2 | 0 = ok, 1 = rejected, 2 = aborted |
| res_bytes | output | 23 | Bytes successfully written |

## Verification
A wrong attempt counter can only be seen after many sequencer errors, so the bench drives long error runs. These runs check that the abort comes on exactly the 10th failure, one cycle later in REPORT. A mistake in block counting or clipping shows up in the first job presented, because the block index or length is wrong. It also shows up one cycle after the last program done, as an extra or missing job, or as a byte total that does not match. Corrupt enable flags are seen as a wrong accept-or-reject decision on the very next request. Each job's fields are therefore compared against a queue of expected jobs, and each result is compared in the cycle it appears.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ERASE_BLK = 2'd1,
        ST_PROG_BLK  = 2'd2,
        ST_REPORT    = 2'd3
    } guard_state_t;

    localparam logic [1:0] CMD_CLEAR   = 2'b00;
    localparam logic [1:0] CMD_EN_ALL  = 2'b01;
    localparam logic [1:0] CMD_EN_LOW  = 2'b10;

    localparam logic [1:0] RES_OK      = 2'd0;
    localparam logic [1:0] RES_REJECT  = 2'd1;
    localparam logic [1:0] RES_ABORT   = 2'd2;

endpackage

// File: rtl/flash_wr_en_regs.sv
module flash_wr_en_regs
    import flash_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    output logic       en_all,
    output logic       en_low,
    output logic       cmd_bad
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_all  <= 1'b0;
            en_low  <= 1'b0;
            cmd_bad <= 1'b0;
        end else begin
            cmd_bad <= 1'b0;
            if (cmd_valid) begin
                unique case (cmd)
                    CMD_CLEAR: begin
                        en_all <= 1'b0;
                        en_low <= 1'b0;
                    end
                    CMD_EN_ALL: en_all <= 1'b1;
                    CMD_EN_LOW: en_low <= 1'b1;
                    default: begin
                        en_all  <= 1'b0;
                        en_low  <= 1'b0;
                        cmd_bad <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/flash_wr_plan.sv
module flash_wr_plan #(
    parameter int ADDR_W   = 22,
    parameter int BLK_SH   = 16,
    parameter int SMALL_SH = 20,
    localparam int CNT_W   = ADDR_W + 1,
    localparam int SUM_W   = CNT_W + 1,
    localparam int LAST_W  = SUM_W - BLK_SH
) (
    input  logic [ADDR_W-1:0] start,
    input  logic [CNT_W-1:0]  count,
    input  logic              size_sel,
    input  logic              en_all,
    input  logic              en_low,
    output logic              accept,
    output logic [LAST_W-1:0] nblk
);

    logic [SUM_W-1:0]  end_addr;
    logic [SUM_W-1:0]  dev_bytes;
    logic              in_boot;
    logic              fits;
    logic [LAST_W-1:0] last_idx;
    logic [LAST_W-1:0] first_idx;
    logic              on_edge;

    always_comb begin
        end_addr  = SUM_W'(start) + SUM_W'(count);
        dev_bytes = size_sel ? (SUM_W'(1) << ADDR_W) : (SUM_W'(1) << SMALL_SH);
        in_boot   = (start[ADDR_W-1:BLK_SH] == '0);
        fits      = (end_addr <= dev_bytes);
        accept    = en_all && (!in_boot || en_low) && fits;
        last_idx  = end_addr[SUM_W-1:BLK_SH];
        first_idx = LAST_W'(start[ADDR_W-1:BLK_SH]);
        on_edge   = (end_addr[BLK_SH-1:0] == '0);
        nblk      = last_idx - first_idx + LAST_W'(1) - (on_edge ? LAST_W'(1) : LAST_W'(0));
    end

endmodule

// File: rtl/flash_wr_span.sv
module flash_wr_span #(
    parameter int ADDR_W  = 22,
    parameter int BLK_SH  = 16,
    localparam int CNT_W  = ADDR_W + 1,
    localparam int LEN_W  = BLK_SH + 1,
    localparam int BLK_W  = ADDR_W - BLK_SH
) (
    input  logic [ADDR_W-1:0] pos,
    input  logic [CNT_W-1:0]  remain,
    output logic [BLK_W-1:0]  blk,
    output logic [BLK_SH-1:0] off,
    output logic [LEN_W-1:0]  len
);

    logic [LEN_W-1:0] room;

    always_comb begin
        blk  = pos[ADDR_W-1:BLK_SH];
        off  = pos[BLK_SH-1:0];
        room = (LEN_W'(1) << BLK_SH) - LEN_W'(off);
        if (remain < CNT_W'(room))
            len = LEN_W'(remain);
        else
            len = room;
    end

endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
    import flash_wr_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int BLK_SH   = 16,
    parameter int SMALL_SH = 20,
    parameter int TRY_MAX  = 10,
    localparam int CNT_W   = ADDR_W + 1,
    localparam int LEN_W   = BLK_SH + 1,
    localparam int BLK_W   = ADDR_W - BLK_SH,
    localparam int LAST_W  = CNT_W + 1 - BLK_SH,
    localparam int TRY_W   = $clog2(TRY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd,
    output logic              cmd_bad,
    input  logic              size_sel,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_start,
    input  logic [CNT_W-1:0]  wr_count,
    output logic              busy,
    output logic              job_valid,
    output logic              job_kind,
    output logic [BLK_W-1:0]  job_blk,
    output logic [BLK_SH-1:0] job_off,
    output logic [LEN_W-1:0]  job_len,
    input  logic              job_done,
    input  logic              job_err,
    output logic              res_valid,
    output logic [1:0]        res_status,
    output logic [CNT_W-1:0]  res_bytes
);

    guard_state_t      state_q, state_d;
    logic              en_all, en_low;
    logic              plan_ok;
    logic [LAST_W-1:0] plan_nblk;
    logic [ADDR_W-1:0] pos_q;
    logic [CNT_W-1:0]  rem_q;
    logic [LAST_W-1:0] left_q;
    logic [CNT_W-1:0]  bytes_q;
    logic [TRY_W-1:0]  etry_q, ptry_q;
    logic [1:0]        status_q;
    logic              erase_last, prog_last, blk_last;

    flash_wr_en_regs u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .en_all    (en_all),
        .en_low    (en_low),
        .cmd_bad   (cmd_bad)
    );

    flash_wr_plan #(.ADDR_W(ADDR_W), .BLK_SH(BLK_SH), .SMALL_SH(SMALL_SH)) u_plan (
        .start    (wr_start),
        .count    (wr_count),
        .size_sel (size_sel),
        .en_all   (en_all),
        .en_low   (en_low),
        .accept   (plan_ok),
        .nblk     (plan_nblk)
    );

    flash_wr_span #(.ADDR_W(ADDR_W), .BLK_SH(BLK_SH)) u_span (
        .pos    (pos_q),
        .remain (rem_q),
        .blk    (job_blk),
        .off    (job_off),
        .len    (job_len)
    );

    assign erase_last = (etry_q + TRY_W'(1) >= TRY_W'(TRY_MAX));
    assign prog_last  = (ptry_q + TRY_W'(1) >= TRY_W'(TRY_MAX));
    assign blk_last   = (left_q == LAST_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_req) begin
                    if (plan_ok && plan_nblk != '0) state_d = ST_ERASE_BLK;
                    else                             state_d = ST_REPORT;
                end
            end
            ST_ERASE_BLK: begin
                if (job_err)       state_d = erase_last ? ST_REPORT : ST_ERASE_BLK;
                else if (job_done) state_d = ST_PROG_BLK;
            end
            ST_PROG_BLK: begin
                if (job_err)       state_d = prog_last ? ST_REPORT : ST_ERASE_BLK;
                else if (job_done) state_d = blk_last ? ST_REPORT : ST_ERASE_BLK;
            end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-request working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            rem_q    <= '0;
            left_q   <= '0;
            bytes_q  <= '0;
            etry_q   <= '0;
            ptry_q   <= '0;
            status_q <= RES_OK;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_req) begin
                        pos_q    <= wr_start;
                        rem_q    <= wr_count;
                        left_q   <= plan_nblk;
                        bytes_q  <= '0;
                        etry_q   <= '0;
                        ptry_q   <= '0;
                        status_q <= plan_ok ? RES_OK : RES_REJECT;
                    end
                end
                ST_ERASE_BLK: begin
                    if (job_err || job_done) etry_q <= etry_q + TRY_W'(1);
                    if (job_err && erase_last) status_q <= RES_ABORT;
                end
                ST_PROG_BLK: begin
                    if (job_err) begin
                        ptry_q <= ptry_q + TRY_W'(1);
                        if (prog_last) status_q <= RES_ABORT;
                    end else if (job_done) begin
                        pos_q   <= pos_q + ADDR_W'(job_len);
                        rem_q   <= rem_q - CNT_W'(job_len);
                        bytes_q <= bytes_q + CNT_W'(job_len);
                        left_q  <= left_q - LAST_W'(1);
                        etry_q  <= '0;
                        ptry_q  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        busy       = (state_q != ST_IDLE);
        job_valid  = (state_q == ST_ERASE_BLK) || (state_q == ST_PROG_BLK);
        job_kind   = (state_q == ST_PROG_BLK);
        res_valid  = (state_q == ST_REPORT);
        res_status = status_q;
        res_bytes  = bytes_q;
    end

endmodule

// File: rtl/flash_wr_guard_chk.sv
module flash_wr_guard_chk #(
    parameter int BLK_SH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd,
    input logic              cmd_bad,
    input logic              busy,
    input logic              job_valid,
    input logic              job_kind,
    input logic [5:0]        job_blk,
    input logic [BLK_SH-1:0] job_off,
    input logic [BLK_SH:0]   job_len,
    input logic              job_done,
    input logic              job_err,
    input logic              res_valid,
    input logic [1:0]        res_status,
    input logic [22:0]       res_bytes
);

    // R1
    bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd == 2'b11 |=> cmd_bad);

    // R2
    reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_status == 2'd1 |-> res_bytes == '0);

    // R6
    span_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid |-> ({2'b00, job_off} + {1'b0, job_len}) <= ((BLK_SH+2)'(1) << BLK_SH));

    // R7
    erase_then_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid && !job_kind && job_done && !job_err
        |=> job_valid && job_kind && $stable(job_blk) && $stable(job_off));

    // R12
    idle_no_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !job_valid && !res_valid);

    // R12
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

endmodule

bind flash_wr_guard flash_wr_guard_chk #(.BLK_SH(BLK_SH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd        (cmd),
    .cmd_bad    (cmd_bad),
    .busy       (busy),
    .job_valid  (job_valid),
    .job_kind   (job_kind),
    .job_blk    (job_blk),
    .job_off    (job_off),
    .job_len    (job_len),
    .job_done   (job_done),
    .job_err    (job_err),
    .res_valid  (res_valid),
    .res_status (res_status),
    .res_bytes  (res_bytes)
);

// File: tb/flash_wr_guard_bench.sv
module flash_wr_guard_bench;

    typedef struct packed {
        logic        kind;
        logic [5:0]  blk;
        logic [15:0] off;
        logic [16:0] len;
        logic        err;
    } job_t;

    typedef struct packed {
        logic [1:0]  status;
        logic [22:0] bytes;
    } res_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd = 2'b00;
    logic        cmd_bad;
    logic        size_sel = 1'b1;
    logic        wr_req = 1'b0;
    logic [21:0] wr_start = '0;
    logic [22:0] wr_count = '0;
    logic        busy, job_valid, job_kind;
    logic [5:0]  job_blk;
    logic [15:0] job_off;
    logic [16:0] job_len;
    logic        job_done = 1'b0;
    logic        job_err = 1'b0;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [22:0] res_bytes;

    job_t job_q[$];
    res_t res_q[$];
    int   checks = 0;
    int   fails = 0;
    string tag_q[$];

    always #5 clk = ~clk;

    flash_wr_guard u_flash_wr_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .cmd_bad(cmd_bad),
        .size_sel(size_sel), .wr_req(wr_req), .wr_start(wr_start), .wr_count(wr_count),
        .busy(busy), .job_valid(job_valid), .job_kind(job_kind), .job_blk(job_blk),
        .job_off(job_off), .job_len(job_len), .job_done(job_done), .job_err(job_err),
        .res_valid(res_valid), .res_status(res_status), .res_bytes(res_bytes)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // monitor: acts as the sequencer and scoreboard
    always @(negedge clk) begin
        job_done <= 1'b0;
        job_err  <= 1'b0;
        if (rst_n && job_valid) begin
            if (job_q.size() == 0) begin
                check(1'b0, "R5", "unexpected job blk", longint'(job_blk), 0);
            end else begin
                job_t e;
                e = job_q.pop_front();
                check(job_kind == e.kind, "R7", "job kind", longint'(job_kind), longint'(e.kind));
                check(job_blk == e.blk, "R5", "job block", longint'(job_blk), longint'(e.blk));
                check(job_off == e.off && job_len == e.len, "R6", "job off/len",
                      {job_off, job_len}, {e.off, e.len});
                job_err  <= e.err;
                job_done <= !e.err;
            end
        end
        if (rst_n && res_valid) begin
            if (res_q.size() == 0) begin
                check(1'b0, "R12", "unexpected result", longint'(res_status), 0);
            end else begin
                res_t r;
                string t;
                r = res_q.pop_front();
                t = tag_q.pop_front();
                check(res_status == r.status, t, "result status", longint'(res_status), longint'(r.status));
                check(res_bytes == r.bytes, "R10", "result bytes", longint'(res_bytes), longint'(r.bytes));
            end
        end
    end

    task automatic push_job(input logic kind, input int blk, input int off, input int len, input logic err);
        job_t j;
        j.kind = kind; j.blk = 6'(blk); j.off = 16'(off); j.len = 17'(len); j.err = err;
        job_q.push_back(j);
    endtask

    task automatic push_res(input int status, input int bytes, input string tag);
        res_t r;
        r.status = 2'(status); r.bytes = 23'(bytes);
        res_q.push_back(r);
        tag_q.push_back(tag);
    endtask

    // expected jobs for an error-free accepted write, from R5/R6/R7
    task automatic push_plan(input int start, input int count);
        int first, n, p, rem, len, room;
        first = start >> 16;
        n = ((start + count) >> 16) - first + 1;
        if (((start + count) & 32'hFFFF) == 0) n--;
        p = start; rem = count;
        for (int b = 0; b < n; b++) begin
            room = 32'h10000 - (p & 32'hFFFF);
            len = (rem < room) ? rem : room;
            push_job(1'b0, p >> 16, p & 32'hFFFF, len, 1'b0);
            push_job(1'b1, p >> 16, p & 32'hFFFF, len, 1'b0);
            p += len; rem -= len;
        end
        push_res(0, count, "R5");
    endtask

    task automatic send_cmd(input logic [1:0] c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_bad == (c == 2'b11), "R1", "cmd_bad", longint'(cmd_bad), longint'(c == 2'b11));
    endtask

    task automatic do_write(input int start, input int count, input bit poke_busy);
        @(negedge clk);
        wr_req = 1'b1; wr_start = 22'(start); wr_count = 23'(count);
        @(negedge clk);
        wr_req = 1'b0;
        if (poke_busy) begin
            check(busy == 1'b1, "R12", "busy after accept", longint'(busy), 1);
            // R11: second request while busy must be ignored
            wr_req = 1'b1; wr_start = 22'h000010; wr_count = 23'h7;
            @(negedge clk);
            wr_req = 1'b0;
        end
        while (res_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0 && job_q.size() == 0, "R11", "idle, jobs left",
              longint'(job_q.size()), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && job_valid == 0 && res_valid == 0 && cmd_bad == 0, "R12",
              "reset outputs", {busy, job_valid, res_valid, cmd_bad}, 0);
        rst_n = 1'b1;

        // R2: nothing enabled
        push_res(1, 0, "R2");
        do_write(32'h10000, 32'h100, 0);

        send_cmd(2'b01);
        push_plan(32'h10000, 32'h100);
        do_write(32'h10000, 32'h100, 0);

        // R3: low block without low enable
        push_res(1, 0, "R3");
        do_write(32'h8000, 32'h10, 0);
        send_cmd(2'b10);
        push_plan(32'hFFF0, 32'h20);
        do_write(32'hFFF0, 32'h20, 0);

        // R5: exact boundary end, zero-length cases
        push_plan(32'h20000, 32'h20000);
        do_write(32'h20000, 32'h20000, 0);
        push_res(0, 0, "R5");
        do_write(32'h20000, 0, 0);
        push_plan(32'h20010, 0);
        do_write(32'h20010, 0, 0);
        push_plan(32'h12345, 32'h3_0000);
        do_write(32'h12345, 32'h3_0000, 1);

        // R4: size limit
        size_sel = 1'b0;
        push_plan(32'hF0000, 32'h10000);
        do_write(32'hF0000, 32'h10000, 0);
        push_res(1, 0, "R4");
        do_write(32'hF0000, 32'h10001, 0);
        size_sel = 1'b1;
        push_plan(32'h100000, 32'h10);
        do_write(32'h100000, 32'h10, 0);
        push_plan(32'h3F0000, 32'h10000);
        do_write(32'h3F0000, 32'h10000, 0);
        push_res(1, 0, "R4");
        do_write(32'h3F0000, 32'h10001, 0);

        // R8: nine erase errors then success
        for (int k = 0; k < 9; k++) push_job(1'b0, 3, 0, 16, 1'b1);
        push_job(1'b0, 3, 0, 16, 1'b0);
        push_job(1'b1, 3, 0, 16, 1'b0);
        push_res(0, 16, "R8");
        do_write(32'h30000, 16, 0);
        // R8: ten erase errors abort
        for (int k = 0; k < 10; k++) push_job(1'b0, 3, 0, 16, 1'b1);
        push_res(2, 0, "R8");
        do_write(32'h30000, 16, 0);

        // R9/R10: second block fails verification ten times
        push_job(1'b0, 3, 16'hFFF8, 8, 1'b0);
        push_job(1'b1, 3, 16'hFFF8, 8, 1'b0);
        for (int k = 0; k < 10; k++) begin
            push_job(1'b0, 4, 0, 8, 1'b0);
            push_job(1'b1, 4, 0, 8, 1'b1);
        end
        push_res(2, 8, "R9");
        do_write(32'h3FFF8, 16, 0);

        // R9: one verify failure then success
        push_job(1'b0, 5, 0, 4, 1'b0);
        push_job(1'b1, 5, 0, 4, 1'b1);
        push_job(1'b0, 5, 0, 4, 1'b0);
        push_job(1'b1, 5, 0, 4, 1'b0);
        push_res(0, 4, "R9");
        do_write(32'h50000, 4, 0);

        // R1: clear and invalid commands
        send_cmd(2'b00);
        push_res(1, 0, "R1");
        do_write(32'h20000, 16, 0);
        send_cmd(2'b01);
        send_cmd(2'b11);
        push_res(1, 0, "R1");
        do_write(32'h20000, 16, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule